// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Pair with Trigger Levels

This block holds the character buffers of one UART channel: a receive FIFO filled by the deserializer and drained by the host, and a transmit FIFO filled by the host and drained by the serializer. Each FIFO holds up to 64 entries. A receive entry is an 8-bit character plus three error status bits that travel with it.

Each FIFO has its own trigger level. The level comes from one of two sources. The first is a four-entry fixed menu in the control register. The second is a programmable value in a separate trigger register. The receive request fires when the fill reaches the trigger. The transmit request fires when the free space reaches the trigger. Each request drives both an interrupt line and a DMA-ready line.

With the FIFOs disabled (the reset state), each side acts as a one-character holding register with an effective trigger of one. Host software writes two byte-wide registers:
- Address 0 is the control register. It holds enable, the two flush strobes and the two menu selects.
- Address 1 is the trigger register. It holds the two programmable trigger values.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset the FIFOs are disabled, both counts are 0, the overrun flag is 0, the receive request is 0 and the transmit request is 1.
- R2: While disabled (control bit 0 = 0), each FIFO holds at most one entry, and both effective triggers are 1.
- R3: While enabled (control bit 0 = 1), each FIFO holds 64 entries and returns them in push order at the show-ahead output. A transmit push into a full FIFO is discarded.
- R4: Each receive entry stores 3 error bits with its byte, and they are presented together with that byte.
- R5: A receive push while the receive FIFO is full discards the byte and sets the sticky overrun flag. Only a receive flush clears the flag.
- R6: The receive menu is control bits 7:6, with 00=8, 01=16, 10=56 and 11=60. `rx_irq` and `rxrdy` are 1 exactly when the receive count is at or above the receive trigger.
- R7: The transmit menu is control bits 5:4, with 00=8, 01=16, 10=32 and 11=56. `tx_irq` and `txrdy` are 1 exactly when the free space (capacity minus count) is at or above the transmit trigger.
- R8: Trigger register bits 7:4 set the receive trigger and bits 3:0 set the transmit trigger. A nonzero value n gives a trigger of 4·n, which overrides the menu. A value of 0 selects the menu.
- R9: Control bit 1 flushes only the receive FIFO, and control bit 2 flushes only the transmit FIFO. Both bits are self-clearing. A flush takes priority over a push or a pop in the same cycle.
- R10: A control write that changes the enable bit flushes both FIFOs and clears the overrun flag.
- R11: A pop from an empty FIFO has no effect. A push and a pop in the same cycle on a FIFO that is neither full nor empty leave its count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = control, 1 = trigger register |
| cfg_wdata | input | 8 | Register write data |
| rx_push | input | 1 | Deserializer writes a character |
| rx_din | input | 8 | Received character |
| rx_err_in | input | 3 | Error status of the received character |
| rx_pop | input | 1 | Host reads the receive head |
| rx_dout | output | 8 | Receive head character |
| rx_err_out | output | 3 | Receive head error status |
| rx_count | output | 7 | Receive fill |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| tx_push | input | 1 | Host writes a character |
| tx_din | input | 8 | Character to transmit |
| tx_pop | input | 1 | Serializer takes the transmit head |
| tx_dout | output | 8 | Transmit head character |
| tx_count | output | 7 | Transmit fill |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_irq | output | 1 | Receive interrupt request |
| rxrdy | output | 1 | Receive DMA ready |
| tx_irq | output | 1 | Transmit interrupt request |
| txrdy | output | 1 | Transmit DMA ready |

## Verification
A behavioural queue model runs alongside the design and is compared every clock. The stimulus has several parts:
- Fills in disabled mode separate the one-entry holding behaviour from true FIFO operation.
- Full 64-entry fills with a changing error pattern expose ordering, width and overflow-discard faults.
- Fills under each of the four menu codes on both sides, then under programmable values, show which trigger source is applied. They also show whether the comparison is against fill or against free space.
- Flushes issued together with pushes, pops on an empty FIFO and enable toggles isolate the priority and side-effect rules.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
   localparam int DATA_W   = 8;
   localparam int ERR_W    = 3;
   localparam int SEL_W    = 2;
   localparam int PROG_W   = 4;
   localparam int TRIG_UNIT = 4;

   localparam bit ADDR_CTRL = 1'b0;
   localparam bit ADDR_TRIG = 1'b1;

   localparam int CB_EN      = 0;
   localparam int CB_RXFLUSH = 1;
   localparam int CB_TXFLUSH = 2;
   localparam int CB_TXSEL   = 4;
   localparam int CB_RXSEL   = 6;
   localparam int TB_TXPROG  = 0;
   localparam int TB_RXPROG  = 4;

   localparam int RX_MENU0 = 8;
   localparam int RX_MENU1 = 16;
   localparam int RX_MENU2 = 56;
   localparam int RX_MENU3 = 60;
   localparam int TX_MENU0 = 8;
   localparam int TX_MENU1 = 16;
   localparam int TX_MENU2 = 32;
   localparam int TX_MENU3 = 56;

   typedef struct packed {
      logic [SEL_W-1:0] rx_sel;
      logic [SEL_W-1:0] tx_sel;
      logic             en;
   } fifo_ctrl_t;
endpackage

// File: rtl/ufifo_ring.sv
module ufifo_ring #(
   parameter int W     = 8,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic [CW-1:0] cap,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          drop
);
   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("ufifo_ring: DEPTH must be a power of two");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          full, do_push, do_pop;

   assign full    = (count >= cap);
   assign do_push = push && !full;
   assign do_pop  = pop && (count != '0);
   assign drop    = push && full && !flush;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R3: fill never exceeds the active capacity
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count <= cap);
   // R11: popping an empty FIFO leaves it empty
   a_r11_empty_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && pop && !push && !flush) |=> (count == '0));
   // R9: flush empties on the next edge
   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0));
endmodule

// File: rtl/ufifo_trigger.sv
module ufifo_trigger
   import uart_fifo_pkg::*;
#(
   parameter bit IS_RX = 1'b1,
   parameter int CW    = 7,
   parameter int M0    = 8,
   parameter int M1    = 16,
   parameter int M2    = 32,
   parameter int M3    = 56
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [SEL_W-1:0]  sel,
   input  logic [PROG_W-1:0] prog,
   input  logic [CW-1:0]     count,
   input  logic [CW-1:0]     cap,
   output logic [CW-1:0]     trig,
   output logic              req
);
   if (M3 >= (1 << (CW - 1)) + 1) begin : g_bad_menu
      $error("ufifo_trigger: menu value exceeds depth");
   end

   logic [CW-1:0] menu_val;

   always_comb begin
      case (sel)
         2'd0:    menu_val = CW'(M0);
         2'd1:    menu_val = CW'(M1);
         2'd2:    menu_val = CW'(M2);
         default: menu_val = CW'(M3);
      endcase
      if (!en)              trig = CW'(1);
      else if (prog != '0)  trig = CW'(prog) * CW'(TRIG_UNIT);
      else                  trig = menu_val;
   end

   if (IS_RX) begin : g_fill
      assign req = (count >= trig);
   end else begin : g_space
      logic [CW-1:0] space;
      assign space = cap - count;
      assign req   = (space >= trig);
   end

   // R8: a trigger is always between 1 and the capacity
   a_r8_trig_range: assert property (@(posedge clk) disable iff (!rst_n)
      (trig != '0) && (trig <= cap));
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
   import uart_fifo_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int CW   = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_addr,
   input  logic [7:0]        cfg_wdata,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_din,
   input  logic [ERR_W-1:0]  rx_err_in,
   input  logic              rx_pop,
   output logic [DATA_W-1:0] rx_dout,
   output logic [ERR_W-1:0]  rx_err_out,
   output logic [CW-1:0]     rx_count,
   output logic              rx_empty,
   output logic              rx_overrun,
   input  logic              tx_push,
   input  logic [DATA_W-1:0] tx_din,
   input  logic              tx_pop,
   output logic [DATA_W-1:0] tx_dout,
   output logic [CW-1:0]     tx_count,
   output logic              tx_empty,
   output logic              rx_irq,
   output logic              rxrdy,
   output logic              tx_irq,
   output logic              txrdy
);
   if (DEPTH < 64) begin : g_bad_depth
      $error("uart_fifo_pair: DEPTH must be at least 64");
   end

   localparam int RXW = DATA_W + ERR_W;

   fifo_ctrl_t        ctrl;
   logic [PROG_W-1:0] rx_prog, tx_prog;
   logic              ctrl_wr, en_chg, rx_flush, tx_flush, rx_drop, tx_drop;
   logic [CW-1:0]     cap, rx_trig, tx_trig;
   logic              rx_req, tx_req;
   logic [RXW-1:0]    rx_head;

   assign ctrl_wr  = cfg_we && (cfg_addr == ADDR_CTRL);
   assign en_chg   = ctrl_wr && (cfg_wdata[CB_EN] != ctrl.en);
   assign rx_flush = (ctrl_wr && cfg_wdata[CB_RXFLUSH]) || en_chg;
   assign tx_flush = (ctrl_wr && cfg_wdata[CB_TXFLUSH]) || en_chg;
   assign cap      = ctrl.en ? CW'(DEPTH) : CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= '0;
         rx_prog <= '0;
         tx_prog <= '0;
      end else if (cfg_we) begin
         if (cfg_addr == ADDR_CTRL) begin
            ctrl.en     <= cfg_wdata[CB_EN];
            ctrl.tx_sel <= cfg_wdata[CB_TXSEL +: SEL_W];
            ctrl.rx_sel <= cfg_wdata[CB_RXSEL +: SEL_W];
         end else begin
            rx_prog <= cfg_wdata[TB_RXPROG +: PROG_W];
            tx_prog <= cfg_wdata[TB_TXPROG +: PROG_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rx_overrun <= 1'b0;
      else if (rx_flush) rx_overrun <= 1'b0;
      else if (rx_drop)  rx_overrun <= 1'b1;
   end

   ufifo_ring #(.W(RXW), .DEPTH(DEPTH)) u_rx_ring (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush), .cap(cap),
      .push(rx_push), .din({rx_err_in, rx_din}), .pop(rx_pop),
      .dout(rx_head), .count(rx_count), .drop(rx_drop)
   );

   ufifo_ring #(.W(DATA_W), .DEPTH(DEPTH)) u_tx_ring (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush), .cap(cap),
      .push(tx_push), .din(tx_din), .pop(tx_pop),
      .dout(tx_dout), .count(tx_count), .drop(tx_drop)
   );

   ufifo_trigger #(.IS_RX(1'b1), .CW(CW), .M0(RX_MENU0), .M1(RX_MENU1),
                   .M2(RX_MENU2), .M3(RX_MENU3)) u_rx_trig (
      .clk(clk), .rst_n(rst_n), .en(ctrl.en), .sel(ctrl.rx_sel),
      .prog(rx_prog), .count(rx_count), .cap(cap), .trig(rx_trig), .req(rx_req)
   );

   ufifo_trigger #(.IS_RX(1'b0), .CW(CW), .M0(TX_MENU0), .M1(TX_MENU1),
                   .M2(TX_MENU2), .M3(TX_MENU3)) u_tx_trig (
      .clk(clk), .rst_n(rst_n), .en(ctrl.en), .sel(ctrl.tx_sel),
      .prog(tx_prog), .count(tx_count), .cap(cap), .trig(tx_trig), .req(tx_req)
   );

   assign rx_dout    = rx_head[DATA_W-1:0];
   assign rx_err_out = rx_head[RXW-1:DATA_W];
   assign rx_empty   = (rx_count == '0);
   assign tx_empty   = (tx_count == '0);
   assign rx_irq     = rx_req;
   assign rxrdy      = rx_req;
   assign tx_irq     = tx_req;
   assign txrdy      = tx_req;

   // R5: a push into a full receive FIFO raises overrun
   a_r5_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_count >= cap && !rx_flush) |=> rx_overrun);
   // R2: while disabled no FIFO holds more than one entry
   a_r2_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.en |-> (rx_count <= CW'(1) && tx_count <= CW'(1)));
   // R10: toggling enable clears the overrun flag
   a_r10_toggle_clears: assert property (@(posedge clk) disable iff (!rst_n)
      en_chg |=> (!rx_overrun && rx_count == '0 && tx_count == '0));
endmodule

// File: tb/tb_uart_fifo_pair.sv
module tb_uart_fifo_pair;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic       cfg_we = 0, cfg_addr = 0;
   logic [7:0] cfg_wdata = 0;
   logic       rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
   logic [7:0] rx_din = 0, tx_din = 0;
   logic [2:0] rx_err_in = 0;
   logic [7:0] rx_dout, tx_dout;
   logic [2:0] rx_err_out;
   logic [6:0] rx_count, tx_count;
   logic       rx_empty, tx_empty, rx_overrun, rx_irq, rxrdy, tx_irq, txrdy;

   uart_fifo_pair dut (.*);

   int checks = 0, errors = 0;

   // behavioural reference
   logic [10:0] mrx[$];
   logic [7:0]  mtx[$];
   bit m_en = 0, m_ovr = 0;
   int m_rsel = 0, m_tsel = 0, m_rprog = 0, m_tprog = 0;

   function automatic int etrig(bit rx);
      if (!m_en) return 1;
      if (rx && m_rprog != 0) return 4 * m_rprog;
      if (!rx && m_tprog != 0) return 4 * m_tprog;
      if (rx) case (m_rsel) 0: return 8; 1: return 16; 2: return 56; default: return 60; endcase
      case (m_tsel) 0: return 8; 1: return 16; 2: return 32; default: return 56; endcase
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         int  cap;
         bit  rfl, tfl;
         cap = m_en ? 64 : 1;
         rfl = 0; tfl = 0;
         if (cfg_we && !cfg_addr) begin
            rfl = cfg_wdata[1] || (cfg_wdata[0] != m_en);
            tfl = cfg_wdata[2] || (cfg_wdata[0] != m_en);
         end
         if (rfl) begin mrx.delete(); m_ovr = 0; end
         else begin
            bit full;
            full = (mrx.size() >= cap);
            if (rx_pop && mrx.size() > 0) void'(mrx.pop_front());
            if (rx_push && !full) mrx.push_back({rx_err_in, rx_din});
            else if (rx_push) m_ovr = 1;
         end
         if (tfl) mtx.delete();
         else begin
            bit full;
            full = (mtx.size() >= cap);
            if (tx_pop && mtx.size() > 0) void'(mtx.pop_front());
            if (tx_push && !full) mtx.push_back(tx_din);
         end
         if (cfg_we && !cfg_addr) begin
            m_en = cfg_wdata[0]; m_tsel = cfg_wdata[5:4]; m_rsel = cfg_wdata[7:6];
         end
         if (cfg_we && cfg_addr) begin
            m_rprog = cfg_wdata[7:4]; m_tprog = cfg_wdata[3:0];
         end
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      int cap;
      cap = m_en ? 64 : 1;
      chk("R3 rx_count", rx_count, mrx.size());
      chk("R3 tx_count", tx_count, mtx.size());
      chk("R5 overrun", rx_overrun, m_ovr);
      chk("R6 rx_irq", rx_irq, mrx.size() >= etrig(1));
      chk("R6 rxrdy", rxrdy, mrx.size() >= etrig(1));
      chk("R7 tx_irq", tx_irq, (cap - mtx.size()) >= etrig(0));
      chk("R7 txrdy", txrdy, (cap - mtx.size()) >= etrig(0));
      if (mrx.size() > 0) begin
         chk("R3 rx_dout", rx_dout, mrx[0][7:0]);
         chk("R4 rx_err_out", rx_err_out, mrx[0][10:8]);
      end
      if (mtx.size() > 0) chk("R3 tx_dout", tx_dout, mtx[0]);
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      cfg_we = 0; rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
      compare();
   endtask

   task automatic wr(bit a, logic [7:0] d);
      cfg_we = 1; cfg_addr = a; cfg_wdata = d; tick();
   endtask

   task automatic fill(int nrx, int ntx, int seed);
      for (int i = 0; i < ((nrx > ntx) ? nrx : ntx); i++) begin
         rx_push = (i < nrx); rx_din = 8'(seed + i); rx_err_in = 3'(i + seed);
         tx_push = (i < ntx); tx_din = 8'(seed * 3 + i);
         tick();
      end
   endtask

   task automatic drain();
      while (!rx_empty || !tx_empty) begin
         rx_pop = 1; tx_pop = 1; tick();
      end
   endtask

   initial begin
      #200000;
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      compare();
      chk("R1 reset tx_irq", tx_irq, 1);
      chk("R1 reset rx_irq", rx_irq, 0);
      rst_n = 1;
      tick();
      // R2: disabled holding register
      fill(2, 2, 5);
      chk("R2 rx holds one", rx_count, 1);
      chk("R2 tx holds one", tx_count, 1);
      chk("R2 rx_irq at one", rx_irq, 1);
      drain();
      // R10: enable flushes and clears overrun
      fill(1, 1, 9);
      wr(0, 8'h01);
      chk("R10 enable flush", rx_count, 0);
      chk("R10 overrun cleared", rx_overrun, 0);
      // R3/R4/R5: full fill, overflow
      fill(66, 66, 17);
      chk("R3 rx full", rx_count, 64);
      chk("R5 overrun set", rx_overrun, 1);
      drain();
      chk("R5 overrun sticky", rx_overrun, 1);
      wr(0, 8'h03);
      chk("R5 flush clears overrun", rx_overrun, 0);
      // R6/R7 menu sweep
      for (int s = 0; s < 4; s++) begin
         wr(0, 8'(8'h07 | (s << 6) | (s << 4)));
         fill(62, 62, s * 11);
         drain();
      end
      // R8 programmable trigger rx=20 tx=12
      wr(0, 8'hC1);
      wr(1, 8'h53);
      fill(19, 0, 40);
      chk("R8 rx below prog", rx_irq, 0);
      fill(1, 52, 60);
      chk("R8 rx at prog", rx_irq, 1);
      chk("R8 tx space 12", tx_irq, 1);
      fill(0, 1, 70);
      chk("R8 tx space 11", tx_irq, 0);
      wr(1, 8'h00);
      chk("R8 zero selects menu", rx_irq, 0);
      // R9 independent flushes, priority over push
      rx_push = 1; rx_din = 8'hAA; wr(0, 8'hC3);
      chk("R9 rx flushed", rx_count, 0);
      chk("R9 tx kept", tx_count, 53);
      fill(3, 0, 80);
      tx_push = 1; wr(0, 8'hC5);
      chk("R9 tx flushed", tx_count, 0);
      chk("R9 rx kept", rx_count, 3);
      drain();
      // R11 empty pop, simultaneous push/pop
      rx_pop = 1; tx_pop = 1; tick();
      chk("R11 empty pop rx", rx_count, 0);
      fill(2, 2, 90);
      rx_push = 1; rx_pop = 1; tx_push = 1; tx_pop = 1; tick();
      chk("R11 push+pop rx", rx_count, 2);
      chk("R11 push+pop tx", tx_count, 2);
      // R10 disable flushes
      wr(0, 8'h00);
      chk("R10 disable flush tx", tx_count, 0);
      chk("R10 disable flush rx", rx_count, 0);
      drain();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule